// File: doc/BRIEF.md
# PWM Fault Shutdown Guard

This block sits between a PWM generator and the four bridge output pins (A, B, C, D). In normal operation it passes the generator's four drive levels straight through with every output enable asserted. When a selected fault source goes high, it overrides the pins with a programmed safe state. The override starts in the same cycle, through a purely combinational path. A status flag records the trip. The override is released only on a PWM period boundary.

Three fault inputs can trip the guard: two comparator outputs and one external fault pin. A 3-bit mask chooses which of them count. The pins form two pairs, A/C and B/D. Each pair has its own 2-bit safe state: drive low, drive high or high impedance. The status flag can clear in two ways. With automatic restart enabled, it clears once the synchronized fault is gone. Otherwise software must clear it with a write. Software writes have no effect while a fault is still present. Software may also set the flag to force a shutdown without a fault. A period-start strobe from the PWM generator aligns the release.

Top module: `pwm_trip_guard`

## Requirements
- R1: Bit 0 of `trip_sel` selects `cmp1_trip`, bit 1 selects `cmp2_trip` and bit 2 selects `ext_trip`; the enabled inputs are ORed, and with `trip_sel` = 000 no fault input has any effect on the pins or on `trip_flag`.
- R2: While any selected fault input is high, all four pins show their safe state in that same cycle, with no clock edge needed.
- R3: Pins 0 and 2 (A/C) use `ac_safe` and pins 1 and 3 (B/D) use `bd_safe`. The encodings are: 00 gives out 0 with enable 1, 01 gives out 1 with enable 1, and 1x gives out 0 with enable 0.
- R4: A selected fault that stays high sets `trip_flag` after SYNC_STAGES+1 rising clock edges.
- R5: With `auto_restart` high, `trip_flag` clears on the edge after the synchronized selected fault is gone, unless a write sets it on that edge.
- R6: With `auto_restart` low, `trip_flag` stays set until software writes 0 to it while no synchronized fault is present.
- R7: A write of 0 (`flag_wr` with `flag_wdata` = 0) while the synchronized selected fault is present leaves `trip_flag` at 1.
- R8: A write of 1 sets `trip_flag` on the next edge and forces the safe state with no fault present.
- R9: The safe state persists through any period in which `trip_flag` was set. After the flag clears, normal drive returns only after the next `period_start` pulse.
- R10: During and after reset, `trip_flag` is 0, all enables are 1 and each pin follows `pwm_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 4 | Generator drive for pins A,B,C,D (bits 0..3) |
| cmp1_trip | input | 1 | Comparator 1 fault |
| cmp2_trip | input | 1 | Comparator 2 fault |
| ext_trip | input | 1 | External fault pin |
| trip_sel | input | 3 | Fault source mask |
| ac_safe | input | 2 | Safe state of pins A and C |
| bd_safe | input | 2 | Safe state of pins B and D |
| auto_restart | input | 1 | Clear flag automatically when fault is gone |
| flag_wr | input | 1 | Software write strobe for the status flag |
| flag_wdata | input | 1 | Value written to the status flag |
| period_start | input | 1 | One-cycle pulse at each PWM period start |
| pin_out | output | 4 | Pin levels A,B,C,D |
| pin_oe | output | 4 | Pin output enables A,B,C,D |
| trip_flag | output | 1 | Shutdown status flag |

## Verification
The bench builds the guard with SYNC_STAGES = 3 rather than the default 2. This makes the latency from fault to flag four edges, so an off-by-one in the synchronizer depth or in where the mask is applied shows up as a timing mismatch. The deeper pipe also widens the window in which a fault is already forcing the pins but is not yet visible to the flag logic. In that window the combinational path alone must hold the safe state, and software writes are still accepted.

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] pwm_in,
  input  logic       cmp1_trip,
  input  logic       cmp2_trip,
  input  logic       ext_trip,
  input  logic [2:0] trip_sel,
  input  logic [1:0] ac_safe,
  input  logic [1:0] bd_safe,
  input  logic       auto_restart,
  input  logic       flag_wr,
  input  logic       flag_wdata,
  input  logic       period_start,
  output logic [3:0] pin_out,
  output logic [3:0] pin_oe,
  output logic       trip_flag
);
  localparam int SW = 3 * SYNC_STAGES;

  logic [2:0]    trip_raw;
  logic [SW-1:0] sync_sr;
  logic          trip_now, trip_sync, flag_q, hold_q, force_safe;

  assign trip_raw  = {ext_trip, cmp2_trip, cmp1_trip};
  assign trip_now  = |(trip_raw & trip_sel);
  assign trip_sync = |(sync_sr[SW-1 -: 3] & trip_sel);

  generate
    if (SYNC_STAGES > 1) begin : g_deep
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_sr <= '0;
        else        sync_sr <= {sync_sr[SW-4:0], trip_raw};
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_sr <= '0;
        else        sync_sr <= trip_raw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            flag_q <= 1'b0;
    else if (trip_sync)    flag_q <= 1'b1;
    else if (flag_wr)      flag_q <= flag_wdata;
    else if (auto_restart) flag_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            hold_q <= 1'b0;
    else if (flag_q)       hold_q <= 1'b1;
    else if (period_start) hold_q <= 1'b0;

  assign force_safe = trip_now | flag_q | hold_q;
  assign trip_flag  = flag_q;

  generate
    for (genvar i = 0; i < 4; i++) begin : g_pin
      logic [1:0] st;
      assign st         = (i % 2 == 0) ? ac_safe : bd_safe;
      assign pin_oe[i]  = force_safe ? ~st[1] : 1'b1;
      assign pin_out[i] = force_safe ? (st[0] & ~st[1]) : pwm_in[i];
    end
  endgenerate
endmodule

// File: rtl/pwm_trip_guard_chk.sv
module pwm_trip_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trip_now,
  input logic       trip_sync,
  input logic       hold_q,
  input logic       trip_flag,
  input logic       flag_wr,
  input logic       auto_restart,
  input logic       period_start,
  input logic [1:0] ac_safe,
  input logic [1:0] bd_safe,
  input logic [3:0] pin_out,
  input logic [3:0] pin_oe
);
  AST_TRIP_FORCES_AC: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_now && ac_safe == 2'b01) |-> (pin_out[0] && pin_out[2] && pin_oe[0] && pin_oe[2])); // R2
  AST_BD_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag && bd_safe[1]) |-> (!pin_oe[1] && !pin_oe[3])); // R3
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    trip_sync |=> trip_flag); // R7
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_restart && trip_flag && !flag_wr) |=> trip_flag); // R6
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !period_start) |=> hold_q); // R9
  AST_FLAG_FORCES_AC: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag && ac_safe == 2'b00) |-> (!pin_out[0] && !pin_out[2] && pin_oe[0] && pin_oe[2])); // R8
endmodule

bind pwm_trip_guard pwm_trip_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trip_now(trip_now), .trip_sync(trip_sync),
  .hold_q(hold_q), .trip_flag(trip_flag), .flag_wr(flag_wr),
  .auto_restart(auto_restart), .period_start(period_start),
  .ac_safe(ac_safe), .bd_safe(bd_safe), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/pwm_trip_guard_tb.sv
`timescale 1ns/1ps
module pwm_trip_guard_tb;
  localparam int SYNC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] pwm_in = '0;
  logic cmp1 = 0, cmp2 = 0, ext = 0;
  logic [2:0] sel = '0;
  logic [1:0] ac = '0, bd = '0;
  logic ar = 0, wr = 0, wd = 0, ps = 0;
  logic [3:0] pin_out, pin_oe;
  logic flag;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_trip_guard #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .cmp1_trip(cmp1), .cmp2_trip(cmp2),
    .ext_trip(ext), .trip_sel(sel), .ac_safe(ac), .bd_safe(bd), .auto_restart(ar),
    .flag_wr(wr), .flag_wdata(wd), .period_start(ps),
    .pin_out(pin_out), .pin_oe(pin_oe), .trip_flag(flag));

  logic [2:0] m_pipe [SYNC];
  logic m_flag, m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) m_pipe[k] <= '0;
      m_flag <= 0; m_hold <= 0;
    end else begin
      if (|(m_pipe[SYNC-1] & sel)) m_flag <= 1;
      else if (wr)                 m_flag <= wd;
      else if (ar)                 m_flag <= 0;
      if (m_flag)  m_hold <= 1;
      else if (ps) m_hold <= 0;
      m_pipe[0] <= {ext, cmp2, cmp1};
      for (int k = 1; k < SYNC; k++) m_pipe[k] <= m_pipe[k-1];
    end
  end

  function automatic logic [8:0] expect_out();
    logic forced;
    logic [3:0] o, e;
    logic [1:0] st;
    forced = rst_n && (m_flag || m_hold || |({ext, cmp2, cmp1} & sel));
    for (int i = 0; i < 4; i++) begin
      st = (i % 2 == 0) ? ac : bd;
      if (!forced) begin o[i] = pwm_in[i]; e[i] = 1; end
      else begin o[i] = st[1] ? 1'b0 : st[0]; e[i] = ~st[1]; end
    end
    return {(rst_n ? m_flag : 1'b0), e, o};
  endfunction

  task automatic step(input string tag);
    logic [8:0] exp_v;
    pwm_in = 4'($urandom);
    #1;
    exp_v = expect_out();
    vectors++;
    if ({flag, pin_oe, pin_out} !== exp_v) begin
      errors++;
      $display("FAIL %s: flag/oe/out got %b/%b/%b expected %b/%b/%b", tag,
               flag, pin_oe, pin_out, exp_v[8], exp_v[7:4], exp_v[3:0]);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic sw_write(input logic v, input string tag);
    wr = 1; wd = v; step(tag); wr = 0;
  endtask

  task automatic period(input string tag);
    ps = 1; step(tag); ps = 0;
  endtask

  task automatic clean(input string tag);
    cmp1 = 0; cmp2 = 0; ext = 0; run(SYNC + 2, tag);
    sw_write(0, tag); period(tag); run(2, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    run(3, "R10");
    rst_n = 1;
    run(3, "R10");

    // R1: nothing selected, all faults high
    sel = 3'b000; cmp1 = 1; cmp2 = 1; ext = 1; run(8, "R1");
    cmp1 = 0; cmp2 = 0; ext = 0; run(2, "R1");
    // R1: each mask bit against each source
    for (int s = 1; s < 8; s++) begin
      for (int f = 0; f < 3; f++) begin
        sel = 3'(s); ac = 2'b01; bd = 2'b00;
        {ext, cmp2, cmp1} = 3'(1 << f);
        run(SYNC + 2, "R1");
        clean("R1");
      end
    end

    // R2/R3/R4: immediate force then flag after SYNC+1 edges
    ar = 0; sel = 3'b100; ac = 2'b00; bd = 2'b01;
    ext = 1; step("R2");
    run(SYNC + 1, "R4");
    for (int s = 0; s < 16; s++) begin ac = 2'(s); bd = 2'(s >> 2); step("R3"); end
    // R7: clear attempt while fault present
    sw_write(0, "R7"); run(2, "R7");
    // R6: fault gone, flag holds without restart
    ext = 0; run(SYNC + 4, "R6");
    period("R6");
    sw_write(0, "R6");
    // R9: still forced until next period start
    run(3, "R9"); period("R9"); run(3, "R9");

    // R5: auto restart
    ar = 1; sel = 3'b011; cmp2 = 1; run(SYNC + 3, "R5");
    cmp2 = 0; run(SYNC + 3, "R5");
    period("R5"); run(2, "R5");
    // R9: period start while flag still set -> whole period held
    cmp1 = 1; run(SYNC + 2, "R9"); period("R9"); cmp1 = 0; run(SYNC + 3, "R9");
    period("R9"); run(2, "R9");

    // R8: software forced shutdown
    ar = 0; sel = 3'b111; ac = 2'b10; bd = 2'b11;
    sw_write(1, "R8"); run(3, "R8"); period("R8"); sw_write(0, "R8");
    period("R8"); run(2, "R8");

    // mixed random
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 15) == 0) {ext, cmp2, cmp1} = 3'($urandom);
      if ($urandom_range(0, 31) == 0) sel = 3'($urandom);
      if ($urandom_range(0, 31) == 0) ar = 1'($urandom);
      ac = 2'($urandom); bd = 2'($urandom);
      wr = ($urandom_range(0, 19) == 0); wd = 1'($urandom);
      ps = ($urandom_range(0, 11) == 0);
      step("R9");
    end
    wr = 0; ps = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule